// File: doc/BRIEF.md
# Four-Level CPU Clock Level Controller

This block keeps the clock configuration for four CPU performance levels and presents the configuration of the active level to a downstream clock generator. Level 0 is the fastest (1.2 GHz nominal), followed by level 1 (600 MHz), level 2 (300 MHz) and level 3 (200 MHz). Each level has a 2-bit source select, a 1-bit clock select and a 3-bit divide value. A dynamic-scaling enable chooses between these per-level settings and a single static setting.

Software uses a simple register port. A write to the load register requests a level change. A request that would jump from level 2 or 3 straight to level 0 is split into two steps. The controller first moves to level 1, then holds there for a settling time counted in reference-clock cycles, and only then enters level 0. A request that arrives during this wait is kept and carried out once the wait ends.

Top module: `dvfs_level_ctrl`

## Requirements
- R1: After reset the current level is 0, `busy_o` is low, all outputs are zero, and every register reads zero.
- R2: Register 0x18 holds levels 0 (bits 31:16) and 1 (bits 15:0). Register 0x1C holds levels 2 (bits 31:16) and 3 (bits 15:0). Within each 16-bit half, the source select is at [10:9], the clock select at [11] and the divider at [15:13]. A read returns only these bits and zero elsewhere.
- R3: Bit 31 of register 0x24 is the dynamic-scaling enable, and all other bits of 0x24 read zero. While the enable is set, `src_sel_o`, `clk_sel_o` and `div_o` carry the fields of the current level.
- R4: While dynamic scaling is off, the outputs carry the static register 0x00. Its fields are source [1:0], clock select [2] and divider [6:4]; all other bits read zero.
- R5: A write to 0x00 while dynamic scaling is off also copies its source field into the source field of all four levels. While dynamic scaling is on, such a write leaves the level fields unchanged.
- R6: A write to 0x30 with bits [1:0] = L, made while not busy and not a slow-to-top jump, makes L the current level on the next clock edge. Reading 0x30 returns the current level in bits [1:0].
- R7: A request for level 0 while the current level is 2 or 3 moves the level to 1 on the next edge and raises `busy_o`. The level stays at 1 with `busy_o` high for exactly SETTLE_CYC cycles, and then becomes 0 as `busy_o` falls.
- R8: A level request written while `busy_o` is high is held; the most recent one wins. It is applied on the edge after `busy_o` falls.
- R9: `busy_o` is high only during the settling wait, and always with level 1. A move from level 1 to level 0 is direct and never raises it.
- R10: A write to an unmapped address changes nothing, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| src_sel_o | output | 2 | Active source select |
| clk_sel_o | output | 1 | Active clock select |
| div_o | output | 3 | Active divide value |
| cur_level_o | output | 2 | Current load level |
| busy_o | output | 1 | Settling wait in progress |

## Verification
The critical collision is a new level request landing on the same edge where the settling counter expires. On that edge the sequencer moves to level 0 and must also capture the request, rather than act on it or lose it. The bench counts cycles from the detour request and writes a level-3 request exactly on the expiry edge. It then checks that level 0 appears first and level 3 one edge later. A second case overwrites a held request twice during the wait, to show that only the latest request is applied.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned LVL_N  = 4;
  localparam int unsigned LVL_W  = 2;
  localparam int unsigned SRC_W  = 2;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned HALF_W = 16;

  // field positions inside one 16-bit level half
  localparam int unsigned SRC_LSB  = 9;
  localparam int unsigned CSEL_LSB = 11;
  localparam int unsigned DIV_LSB  = 13;

  // static register layout
  localparam int unsigned ST_SRC_LSB  = 0;
  localparam int unsigned ST_CSEL_LSB = 2;
  localparam int unsigned ST_DIV_LSB  = 4;

  localparam int unsigned DYN_EN_BIT = 31;

  localparam logic [7:0] OFF_STAT = 8'h00;
  localparam logic [7:0] OFF_LV01 = 8'h18;
  localparam logic [7:0] OFF_LV23 = 8'h1C;
  localparam logic [7:0] OFF_DYN  = 8'h24;
  localparam logic [7:0] OFF_LOAD = 8'h30;

  localparam logic [LVL_W-1:0] LVL_TOP = 2'd0;
  localparam logic [LVL_W-1:0] LVL_MID = 2'd1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             csel;
    logic [SRC_W-1:0] src;
  } lvl_cfg_t;

  function automatic logic [HALF_W-1:0] half_pack(input lvl_cfg_t c);
    logic [HALF_W-1:0] h;
    h = '0;
    h[SRC_LSB +: SRC_W] = c.src;
    h[CSEL_LSB]         = c.csel;
    h[DIV_LSB +: DIV_W] = c.div;
    return h;
  endfunction

  function automatic lvl_cfg_t half_unpack(input logic [HALF_W-1:0] h);
    lvl_cfg_t c;
    c.src  = h[SRC_LSB +: SRC_W];
    c.csel = h[CSEL_LSB];
    c.div  = h[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] stat_pack(input lvl_cfg_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[ST_SRC_LSB +: SRC_W] = c.src;
    r[ST_CSEL_LSB]         = c.csel;
    r[ST_DIV_LSB +: DIV_W] = c.div;
    return r;
  endfunction

  function automatic lvl_cfg_t stat_unpack(input logic [REG_W-1:0] r);
    lvl_cfg_t c;
    c.src  = r[ST_SRC_LSB +: SRC_W];
    c.csel = r[ST_CSEL_LSB];
    c.div  = r[ST_DIV_LSB +: DIV_W];
    return c;
  endfunction
endpackage

// File: rtl/dvfs_regs.sv
module dvfs_regs
  import dvfs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  input  logic [LVL_W-1:0]              cur_level_i,
  output logic [REG_W-1:0]              rdata_o,
  output lvl_cfg_t [LVL_N-1:0]          lvl_cfg_o,
  output lvl_cfg_t                      stat_cfg_o,
  output logic                          dyn_en_o,
  output logic                          load_wr_o,
  output logic [LVL_W-1:0]              load_val_o
);
  logic wr_stat, wr_dyn;
  lvl_cfg_t stat_q;
  logic     dyn_q;
  logic     unused_wdata;

  assign wr_stat      = wr_en_i && (addr_i == ADDR_W'(OFF_STAT));
  assign wr_dyn       = wr_en_i && (addr_i == ADDR_W'(OFF_DYN));
  assign load_wr_o    = wr_en_i && (addr_i == ADDR_W'(OFF_LOAD));
  assign load_val_o   = wdata_i[LVL_W-1:0];
  assign unused_wdata = ^wdata_i;

  // one storage slot per level; the even level of a pair sits in the upper half
  for (genvar k = 0; k < LVL_N; k++) begin : g_lvl
    localparam logic [7:0]  REG_OFF = (k < 2) ? OFF_LV01 : OFF_LV23;
    localparam int unsigned HALF_LO = (k % 2 == 0) ? HALF_W : 0;
    lvl_cfg_t cfg_q;
    logic     wr_mine;
    assign wr_mine = wr_en_i && (addr_i == ADDR_W'(REG_OFF));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
      end else if (wr_mine) begin
        cfg_q <= half_unpack(wdata_i[HALF_LO +: HALF_W]);
      end else if (wr_stat && !dyn_q) begin
        cfg_q.src <= wdata_i[ST_SRC_LSB +: SRC_W];
      end
    end
    assign lvl_cfg_o[k] = cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      dyn_q  <= 1'b0;
    end else begin
      if (wr_stat) stat_q <= stat_unpack(wdata_i);
      if (wr_dyn)  dyn_q  <= wdata_i[DYN_EN_BIT];
    end
  end

  assign stat_cfg_o = stat_q;
  assign dyn_en_o   = dyn_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_STAT)) begin
      rdata_o = stat_pack(stat_q);
    end else if (addr_i == ADDR_W'(OFF_LV01)) begin
      rdata_o = {half_pack(lvl_cfg_o[0]), half_pack(lvl_cfg_o[1])};
    end else if (addr_i == ADDR_W'(OFF_LV23)) begin
      rdata_o = {half_pack(lvl_cfg_o[2]), half_pack(lvl_cfg_o[3])};
    end else if (addr_i == ADDR_W'(OFF_DYN)) begin
      rdata_o[DYN_EN_BIT] = dyn_q;
    end else if (addr_i == ADDR_W'(OFF_LOAD)) begin
      rdata_o[LVL_W-1:0] = cur_level_i;
    end
  end
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 2_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_vld_i,
  input  logic [LVL_W-1:0] req_lvl_i,
  output logic [LVL_W-1:0] cur_level_o,
  output logic             busy_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

  typedef enum logic {SQ_IDLE, SQ_SETTLE} seq_st_e;

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LVL_W-1:0] cur_q, pend_lvl_q, go_lvl;
  logic             pend_vld_q, go;

  // a fresh write overrides a held request
  assign go     = (st_q == SQ_IDLE) && (req_vld_i || pend_vld_q);
  assign go_lvl = req_vld_i ? req_lvl_i : pend_lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      cnt_q      <= '0;
      cur_q      <= LVL_TOP;
      pend_vld_q <= 1'b0;
      pend_lvl_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (go) begin
            pend_vld_q <= 1'b0;
            if (go_lvl == LVL_TOP && cur_q > LVL_MID) begin
              cur_q <= LVL_MID;
              cnt_q <= CNT_W'(SETTLE_CYC - 1);
              st_q  <= SQ_SETTLE;
            end else begin
              cur_q <= go_lvl;
            end
          end
        end
        SQ_SETTLE: begin
          if (req_vld_i) begin
            pend_vld_q <= 1'b1;
            pend_lvl_q <= req_lvl_i;
          end
          if (cnt_q == '0) begin
            cur_q <= LVL_TOP;
            st_q  <= SQ_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign cur_level_o = cur_q;
  assign busy_o      = (st_q == SQ_SETTLE);
endmodule

// File: rtl/dvfs_field_sel.sv
module dvfs_field_sel
  import dvfs_pkg::*;
(
  input  lvl_cfg_t [LVL_N-1:0] lvl_cfg_i,
  input  lvl_cfg_t             stat_cfg_i,
  input  logic                 dyn_en_i,
  input  logic [LVL_W-1:0]     cur_level_i,
  output lvl_cfg_t             act_cfg_o
);
  always_comb begin
    act_cfg_o = stat_cfg_i;
    if (dyn_en_i) act_cfg_o = lvl_cfg_i[cur_level_i];
  end
endmodule

// File: rtl/dvfs_level_ctrl.sv
module dvfs_level_ctrl
  import dvfs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned SETTLE_CYC = 2_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [1:0]        src_sel_o,
  output logic              clk_sel_o,
  output logic [2:0]        div_o,
  output logic [1:0]        cur_level_o,
  output logic              busy_o
);
  lvl_cfg_t [LVL_N-1:0] lvl_cfg;
  lvl_cfg_t             stat_cfg, act_cfg;
  logic                 dyn_en, load_wr;
  logic [LVL_W-1:0]     load_val, cur_level;

  dvfs_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .cur_level_i (cur_level),
    .rdata_o     (rdata_o),
    .lvl_cfg_o   (lvl_cfg),
    .stat_cfg_o  (stat_cfg),
    .dyn_en_o    (dyn_en),
    .load_wr_o   (load_wr),
    .load_val_o  (load_val)
  );

  dvfs_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_vld_i   (load_wr),
    .req_lvl_i   (load_val),
    .cur_level_o (cur_level),
    .busy_o      (busy_o)
  );

  dvfs_field_sel u_sel (
    .lvl_cfg_i   (lvl_cfg),
    .stat_cfg_i  (stat_cfg),
    .dyn_en_i    (dyn_en),
    .cur_level_i (cur_level),
    .act_cfg_o   (act_cfg)
  );

  assign src_sel_o   = act_cfg.src;
  assign clk_sel_o   = act_cfg.csel;
  assign div_o       = act_cfg.div;
  assign cur_level_o = cur_level;
endmodule

// File: rtl/dvfs_level_ctrl_chk.sv
module dvfs_level_ctrl_chk
  import dvfs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned SETTLE_CYC = 2_000_000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        req_lvl_i,
  input logic [1:0]        cur_level_o,
  input logic              busy_o
);
  logic        ld_wr, detour;
  int unsigned busy_run;

  assign ld_wr  = wr_en_i && (addr_i == ADDR_W'(OFF_LOAD));
  assign detour = (req_lvl_i == LVL_TOP) && (cur_level_o > LVL_MID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= 0;
  end

  // R7
  detour_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_wr && !busy_o && detour) |=> (busy_o && cur_level_o == LVL_MID));

  // R6
  direct_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_wr && !busy_o && !detour) |=> (!busy_o && cur_level_o == $past(req_lvl_i)));

  // R9
  busy_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cur_level_o == LVL_MID));

  // R7
  settle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (cur_level_o == LVL_TOP && busy_run == SETTLE_CYC));

  // R7
  settle_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_run < SETTLE_CYC));
endmodule

bind dvfs_level_ctrl dvfs_level_ctrl_chk #(
  .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .req_lvl_i   (wdata_i[1:0]),
  .cur_level_o (cur_level_o),
  .busy_o      (busy_o)
);

// File: tb/dvfs_level_ctrl_bench.sv
module dvfs_level_ctrl_bench;
  localparam int unsigned SETTLE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  src_sel, cur_level;
  logic        clk_sel, busy;
  logic [2:0]  div;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  dvfs_level_ctrl #(.ADDR_W(8), .SETTLE_CYC(SETTLE)) u_dvfs_level_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .src_sel_o(src_sel), .clk_sel_o(clk_sel), .div_o(div),
    .cur_level_o(cur_level), .busy_o(busy)
  );

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] rx;
    logic [5:0]  ox;   // {div, csel, src}
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{8'h18, 32'h2C00_4201, 8'h18, 32'h2C00_4200, {3'd0,1'b0,2'd0}}, // R2 pack, junk bit dropped
    '{8'h1C, 32'h6600_C800, 8'h1C, 32'h6600_C800, {3'd0,1'b0,2'd0}}, // R2
    '{8'h24, 32'h8000_0000, 8'h24, 32'h8000_0000, {3'd1,1'b1,2'd2}}, // R3 level 0 fields
    '{8'h30, 32'h0000_0003, 8'h30, 32'h0000_0003, {3'd6,1'b1,2'd0}}, // R6 R3
    '{8'h30, 32'h0000_0002, 8'h30, 32'h0000_0002, {3'd3,1'b0,2'd3}}, // R6 R3
    '{8'h30, 32'h0000_0001, 8'h30, 32'h0000_0001, {3'd2,1'b0,2'd1}}, // R6 R3
    '{8'h00, 32'h0000_0055, 8'h18, 32'h2C00_4200, {3'd2,1'b0,2'd1}}, // R5 no copy while enabled
    '{8'h24, 32'h0000_0000, 8'h00, 32'h0000_0055, {3'd5,1'b1,2'd1}}, // R4 static drives
    '{8'h00, 32'h0000_0032, 8'h1C, 32'h6400_CC00, {3'd3,1'b0,2'd2}}, // R5 copy to all
    '{8'h40, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000, {3'd3,1'b0,2'd2}}, // R10
    '{8'h24, 32'h7FFF_FFFF, 8'h24, 32'h0000_0000, {3'd3,1'b0,2'd2}}, // R3 only bit 31
    '{8'h00, 32'h0000_00FF, 8'h18, 32'h2E00_4600, {3'd7,1'b1,2'd3}}  // R4 R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 level", {30'd0, cur_level}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 outputs", {26'd0, div, clk_sel, src_sel}, 32'd0);
    foreach (VEC[i]) begin
      rd(VEC[i].ra, r);
      chk("R1 read zero", r, 32'd0);
    end

    // table walk: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, r);
      chk($sformatf("table vec %0d rdata", i), r, VEC[i].rx);
      chk($sformatf("table vec %0d outputs", i), {26'd0, div, clk_sel, src_sel},
          {26'd0, VEC[i].ox});
    end
    rd(8'h18, r);
    chk("R5 levels 0/1 after copy", r, 32'h2E00_4600);

    // R7 detour from level 3 with settling count
    wr(8'h24, 32'h8000_0000);
    wr(8'h30, 32'd3);
    wr(8'h30, 32'd0);
    chk("R7 first step level", {30'd0, cur_level}, 32'd1);
    chk("R7 busy up", {31'd0, busy}, 32'd1);
    chk("R3 level 1 fields during wait", {26'd0, div, clk_sel, src_sel}, {26'd0, 3'd2, 1'b0, 2'd3});
    for (int i = 1; i < SETTLE; i++) begin
      @(negedge clk);
      chk("R7 hold level 1", {30'd0, cur_level}, 32'd1);
      chk("R7 busy hold", {31'd0, busy}, 32'd1);
    end
    @(negedge clk);
    chk("R7 final level", {30'd0, cur_level}, 32'd0);
    chk("R7 busy down", {31'd0, busy}, 32'd0);

    // R8 held requests, latest wins
    wr(8'h30, 32'd2);
    chk("R6 direct to 2", {30'd0, cur_level}, 32'd2);
    wr(8'h30, 32'd0);
    wr(8'h30, 32'd3);
    wr(8'h30, 32'd2);
    chk("R8 still waiting", {31'd0, busy}, 32'd1);
    for (int i = 0; i < 20; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    chk("R8 wait done at level 0", {30'd0, cur_level}, 32'd0);
    @(negedge clk);
    chk("R8 latest held applied", {30'd0, cur_level}, 32'd2);

    // R8 request on the expiry edge
    wr(8'h30, 32'd0);
    repeat (SETTLE - 1) @(negedge clk);
    chk("R8 busy before expiry", {31'd0, busy}, 32'd1);
    wr(8'h30, 32'd3);
    chk("R8 expiry level", {30'd0, cur_level}, 32'd0);
    chk("R8 expiry busy", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R8 same-edge request applied", {30'd0, cur_level}, 32'd3);

    // R9 direct 1 -> 0
    wr(8'h30, 32'd1);
    wr(8'h30, 32'd0);
    chk("R9 no detour from 1", {30'd0, cur_level}, 32'd0);
    chk("R9 busy low", {31'd0, busy}, 32'd0);
    rd(8'h30, r);
    chk("R6 load readback", r, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule